// File: doc/BRIEF.md
# Virtual screen start address calculator

This block keeps the geometry of a panning virtual screen that is larger than the visible display. Software writes a virtual width. From it the block works out the number of bytes per line and the number of whole lines that fit in video memory. It refuses any width that would not cover the visible screen, either horizontally or vertically. Software then writes X and Y pan offsets, and the block turns them into a display start address counted in 32-bit words.

The pixel format, the visible resolution and the memory size are live inputs from the rest of the display controller. Bytes per pixel come from the pixel depth. At 4 bits per pixel two pixels share a byte. Every other depth is rounded up to whole bytes. The line count needs a division, which a bit-serial divider performs. While it runs, `busy_o` is high. Offset writes that arrive during that time are held back and applied once the new line stride is known.

Top module: `vscreen_addr_calc`

## Requirements
- R1: A virtual width write with `vwidth_i` below `xres_i` is rejected: `busy_o` stays low and `vwidth_o`, `vheight_o` and `line_off_o` keep their values.
- R2: The candidate line stride in bytes is `vwidth_i >> 1` when `bpp_i` is 4, and otherwise `vwidth_i * ((bpp_i + 7) >> 3)`.
- R3: The candidate virtual height is the integer quotient of `vram_bytes_i` by the candidate line stride.
- R4: If the candidate height is below `yres_i`, the write is rejected and the three geometry outputs keep their values. A height equal to `yres_i` is accepted.
- R5: On an accepted write, `vwidth_o`, `vheight_o` and `line_off_o` all take their new values on the same clock edge, at the end of the division.
- R6: A write with `xoff_we_i` or `yoff_we_i` stores `off_i` into `xoff_o` or `yoff_o`. Two clock edges after the write, `start_addr_o` equals `(line_off_o * yoff_o + xbytes) >> 2`. Here `xbytes` is `xoff_o * ((bpp_i + 7) >> 3)` at any depth other than 4.
- R7: At 4 bits per pixel, `xbytes` is `xoff_o >> 1`.
- R8: `busy_o` is high from the cycle after an accepted width write until the evaluation ends. An offset write made while busy leaves `xoff_o`, `yoff_o` and `start_addr_o` unchanged until then. It is applied afterwards, and the start address is computed with the new line stride.
- R9: A candidate line stride of zero is rejected without starting a division: `busy_o` stays low and the geometry is unchanged.
- R10: A virtual width write made while `busy_o` is high is ignored.
- R11: After reset, all outputs are zero and `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xres_i | input | DIM_W | Visible horizontal resolution in pixels |
| yres_i | input | DIM_W | Visible vertical resolution in lines |
| bpp_i | input | 6 | Bits per pixel |
| vram_bytes_i | input | MEM_W | Video memory size in bytes |
| vwidth_we_i | input | 1 | Virtual width write strobe |
| vwidth_i | input | DIM_W | Virtual width in pixels |
| xoff_we_i | input | 1 | X pan offset write strobe |
| yoff_we_i | input | 1 | Y pan offset write strobe |
| off_i | input | DIM_W | Pan offset value for either strobe |
| busy_o | output | 1 | Geometry evaluation in progress |
| vwidth_o | output | DIM_W | Accepted virtual width |
| vheight_o | output | MEM_W | Virtual height in lines |
| line_off_o | output | DIM_W+3 | Line stride in bytes |
| xoff_o | output | DIM_W | Current X pan offset |
| yoff_o | output | DIM_W | Current Y pan offset |
| start_addr_o | output | 2*DIM_W+2 | Display start address in 32-bit words |

## Verification
The hardest situation to reach is a pan offset write that lands while a division is still running. It must be held back, and then combined with the stride that the division is about to commit. The bench starts a width change that is known to be accepted. In the busy window it writes both offsets and a second, conflicting width. It checks that nothing visible moves during the window. It then checks that the final start address uses the new stride, not the old one. Rejections near the limits are reached with chosen memory sizes: a height exactly equal to the vertical resolution, one line short of it, and a 4 bits-per-pixel width of 1 that packs to zero bytes.

// File: rtl/vsc_pkg.sv
package vsc_pkg;
  localparam int BPP_W      = 6;
  localparam int PACKED_BPP = 4;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_DIV  = 1'b1
  } vsc_state_e;
endpackage

// File: rtl/vsc_pix_bytes.sv
module vsc_pix_bytes
  import vsc_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int OUT_W = CNT_W + 3
) (
  input  logic [CNT_W-1:0] count_i,
  input  logic [BPP_W-1:0] bpp_i,
  output logic [OUT_W-1:0] bytes_o
);
  logic [BPP_W:0] per_px;

  always_comb begin
    per_px = ({1'b0, bpp_i} + (BPP_W+1)'(7)) >> 3;
    if (bpp_i == BPP_W'(PACKED_BPP))
      bytes_o = OUT_W'(count_i >> 1);
    else
      bytes_o = OUT_W'(count_i) * OUT_W'(per_px);
  end
endmodule

// File: rtl/vsc_seq_div.sv
module vsc_seq_div #(
  parameter int DVD_W = 24,
  parameter int DVS_W = 19,
  localparam int CNT_W  = $clog2(DVD_W + 1),
  localparam int PROD_W = DVD_W + DVS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DVD_W-1:0] dividend_i,
  input  logic [DVS_W-1:0] divisor_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [DVD_W-1:0] quo_o
);
  logic [DVD_W-1:0] dvd_q, quo_q;
  logic [DVS_W-1:0] dvs_q, rem_q, rem_nx;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q;
  logic [DVS_W:0]   shifted, diff;
  logic             take;

  // one restoring step per cycle, MSB first
  always_comb begin
    shifted = {rem_q, quo_q[DVD_W-1]};
    diff    = shifted - {1'b0, dvs_q};
    take    = shifted >= {1'b0, dvs_q};
    rem_nx  = take ? diff[DVS_W-1:0] : shifted[DVS_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dvd_q  <= '0;
      dvs_q  <= '0;
      quo_q  <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (start_i) begin
      dvd_q  <= dividend_i;
      dvs_q  <= divisor_i;
      quo_q  <= dividend_i;
      rem_q  <= '0;
      cnt_q  <= CNT_W'(DVD_W);
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (busy_q) begin
      quo_q <= {quo_q[DVD_W-2:0], take};
      rem_q <= rem_nx;
      cnt_q <= cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign quo_o  = quo_q;

  // R3: quotient and remainder reconstruct the dividend
  p_div_exact_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> ((PROD_W'(quo_q) * PROD_W'(dvs_q) + PROD_W'(rem_q)) == PROD_W'(dvd_q))
               && (rem_q < dvs_q));

  // R9: a zero divisor never reaches the divider
  p_no_div_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (divisor_i != '0));

  p_no_restart_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !start_i);
endmodule

// File: rtl/vsc_start_calc.sv
module vsc_start_calc
  import vsc_pkg::*;
#(
  parameter int DIM_W = 16,
  localparam int LINE_W = DIM_W + 3,
  localparam int SUM_W  = LINE_W + DIM_W + 1,
  localparam int ADDR_W = SUM_W - 2
) (
  input  logic [LINE_W-1:0] line_off_i,
  input  logic [DIM_W-1:0]  xoff_i,
  input  logic [DIM_W-1:0]  yoff_i,
  input  logic [BPP_W-1:0]  bpp_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [LINE_W-1:0] x_bytes;
  logic [SUM_W-1:0]  byte_addr;

  vsc_pix_bytes #(.CNT_W(DIM_W)) u_x_bytes (
    .count_i(xoff_i),
    .bpp_i  (bpp_i),
    .bytes_o(x_bytes)
  );

  always_comb begin
    byte_addr = SUM_W'(line_off_i) * SUM_W'(yoff_i) + SUM_W'(x_bytes);
    addr_o    = byte_addr[SUM_W-1:2];
  end
endmodule

// File: rtl/vscreen_addr_calc.sv
module vscreen_addr_calc
  import vsc_pkg::*;
#(
  parameter int DIM_W = 16,
  parameter int MEM_W = 24,
  localparam int LINE_W = DIM_W + 3,
  localparam int ADDR_W = LINE_W + DIM_W - 1,
  localparam int N_OFF  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIM_W-1:0]  xres_i,
  input  logic [DIM_W-1:0]  yres_i,
  input  logic [BPP_W-1:0]  bpp_i,
  input  logic [MEM_W-1:0]  vram_bytes_i,
  input  logic              vwidth_we_i,
  input  logic [DIM_W-1:0]  vwidth_i,
  input  logic              xoff_we_i,
  input  logic              yoff_we_i,
  input  logic [DIM_W-1:0]  off_i,
  output logic              busy_o,
  output logic [DIM_W-1:0]  vwidth_o,
  output logic [MEM_W-1:0]  vheight_o,
  output logic [LINE_W-1:0] line_off_o,
  output logic [DIM_W-1:0]  xoff_o,
  output logic [DIM_W-1:0]  yoff_o,
  output logic [ADDR_W-1:0] start_addr_o
);
  vsc_state_e        state_q;
  logic [LINE_W-1:0] cand_lo, pend_lo_q, lo_q;
  logic [DIM_W-1:0]  pend_w_q, vw_q;
  logic [MEM_W-1:0]  vh_q, quo;
  logic              div_start, div_busy, div_done, fits, commit;
  logic [ADDR_W-1:0] sa_calc, sa_q;
  logic              recalc_q;
  logic [N_OFF-1:0]  off_we, off_upd;
  logic [DIM_W-1:0]  off_val [N_OFF];

  vsc_pix_bytes #(.CNT_W(DIM_W)) u_lo_bytes (
    .count_i(vwidth_i),
    .bpp_i  (bpp_i),
    .bytes_o(cand_lo)
  );

  assign fits      = (vwidth_i >= xres_i) && (cand_lo != '0);
  assign div_start = (state_q == ST_IDLE) && vwidth_we_i && fits;
  assign commit    = (state_q == ST_DIV) && div_done && (quo >= MEM_W'(yres_i));

  vsc_seq_div #(.DVD_W(MEM_W), .DVS_W(LINE_W)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (div_start),
    .dividend_i(vram_bytes_i),
    .divisor_i (cand_lo),
    .busy_o    (div_busy),
    .done_o    (div_done),
    .quo_o     (quo)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      pend_w_q  <= '0;
      pend_lo_q <= '0;
      vw_q      <= '0;
      vh_q      <= '0;
      lo_q      <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (div_start) begin
          state_q   <= ST_DIV;
          pend_w_q  <= vwidth_i;
          pend_lo_q <= cand_lo;
        end
        ST_DIV: if (div_done) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
      if (commit) begin
        vw_q <= pend_w_q;
        vh_q <= quo;
        lo_q <= pend_lo_q;
      end
    end
  end

  assign off_we = {yoff_we_i, xoff_we_i};

  // per-channel offset storage, deferred while a division runs
  for (genvar ch = 0; ch < N_OFF; ch++) begin : g_off
    logic [DIM_W-1:0] val_q, pend_q;
    logic             pv_q, upd;

    always_comb begin
      upd = 1'b0;
      if (state_q == ST_IDLE) upd = off_we[ch];
      else if (div_done)      upd = off_we[ch] | pv_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        val_q  <= '0;
        pend_q <= '0;
        pv_q   <= 1'b0;
      end else if (state_q == ST_IDLE) begin
        if (off_we[ch]) val_q <= off_i;
      end else if (div_done) begin
        val_q <= off_we[ch] ? off_i : (pv_q ? pend_q : val_q);
        pv_q  <= 1'b0;
      end else if (off_we[ch]) begin
        pend_q <= off_i;
        pv_q   <= 1'b1;
      end
    end

    assign off_val[ch] = val_q;
    assign off_upd[ch] = upd;
  end

  vsc_start_calc #(.DIM_W(DIM_W)) u_start (
    .line_off_i(lo_q),
    .xoff_i    (off_val[0]),
    .yoff_i    (off_val[1]),
    .bpp_i     (bpp_i),
    .addr_o    (sa_calc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      recalc_q <= 1'b0;
      sa_q     <= '0;
    end else begin
      recalc_q <= |off_upd;
      if (recalc_q) sa_q <= sa_calc;
    end
  end

  assign busy_o       = (state_q == ST_DIV);
  assign vwidth_o     = vw_q;
  assign vheight_o    = vh_q;
  assign line_off_o   = lo_q;
  assign xoff_o       = off_val[0];
  assign yoff_o       = off_val[1];
  assign start_addr_o = sa_q;

  p_narrow_reject_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && vwidth_we_i && (vwidth_i < xres_i)) |=>
      (!busy_o && $stable(vwidth_o) && $stable(line_off_o) && $stable(vheight_o)));

  p_short_reject_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && div_done && (quo < MEM_W'(yres_i))) |=>
      ($stable(vwidth_o) && $stable(vheight_o) && $stable(line_off_o)));

  p_geom_at_div_end_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(vwidth_o) || !$stable(line_off_o) || !$stable(vheight_o)) |->
      $past(div_done));

  p_busy_tracks_div_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_busy |-> busy_o);
endmodule

// File: tb/vscreen_addr_calc_bench.sv
`timescale 1ns/1ps
module vscreen_addr_calc_bench;
  localparam int DIM_W  = 16;
  localparam int MEM_W  = 24;
  localparam int LINE_W = DIM_W + 3;
  localparam int ADDR_W = LINE_W + DIM_W - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [DIM_W-1:0]  xres = '0, yres = '0, vwidth = '0, off = '0;
  logic [5:0]        bpp = '0;
  logic [MEM_W-1:0]  vram = '0;
  logic              vwidth_we = 1'b0, xoff_we = 1'b0, yoff_we = 1'b0;
  logic              busy;
  logic [DIM_W-1:0]  vwidth_o, xoff_o, yoff_o;
  logic [MEM_W-1:0]  vheight_o;
  logic [LINE_W-1:0] line_off_o;
  logic [ADDR_W-1:0] start_addr_o;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  vscreen_addr_calc u_vscreen_addr_calc (
    .clk_i(clk), .rst_ni(rst_n),
    .xres_i(xres), .yres_i(yres), .bpp_i(bpp), .vram_bytes_i(vram),
    .vwidth_we_i(vwidth_we), .vwidth_i(vwidth),
    .xoff_we_i(xoff_we), .yoff_we_i(yoff_we), .off_i(off),
    .busy_o(busy), .vwidth_o(vwidth_o), .vheight_o(vheight_o),
    .line_off_o(line_off_o), .xoff_o(xoff_o), .yoff_o(yoff_o),
    .start_addr_o(start_addr_o)
  );

  typedef struct packed {
    logic [15:0] xres;
    logic [15:0] yres;
    logic [5:0]  bpp;
    logic [23:0] vram;
    logic [15:0] vw;
    logic        starts;
    logic [15:0] e_vw;
    logic [18:0] e_lo;
    logic [23:0] e_h;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{16'd640, 16'd480,  6'd8,  24'd1048576,  16'd1024, 1'b1, 16'd1024, 19'd1024, 24'd1024},
    '{16'd640, 16'd480,  6'd16, 24'd1048576,  16'd800,  1'b1, 16'd800,  19'd1600, 24'd655},
    '{16'd800, 16'd600,  6'd32, 24'd1048576,  16'd1024, 1'b1, 16'd800,  19'd1600, 24'd655},
    '{16'd640, 16'd480,  6'd4,  24'd262144,   16'd1280, 1'b1, 16'd800,  19'd1600, 24'd655},
    '{16'd640, 16'd480,  6'd4,  24'd1048576,  16'd1280, 1'b1, 16'd1280, 19'd640,  24'd1638},
    '{16'd640, 16'd480,  6'd24, 24'd1048576,  16'd640,  1'b1, 16'd640,  19'd1920, 24'd546},
    '{16'd640, 16'd480,  6'd15, 24'd1048576,  16'd632,  1'b0, 16'd640,  19'd1920, 24'd546},
    '{16'd640, 16'd480,  6'd15, 24'd1048576,  16'd1000, 1'b1, 16'd1000, 19'd2000, 24'd524},
    '{16'd0,   16'd0,    6'd4,  24'd1048576,  16'd1,    1'b0, 16'd1000, 19'd2000, 24'd524},
    '{16'd8,   16'd0,    6'd32, 24'd16777215, 16'd16,   1'b1, 16'd16,   19'd64,   24'd262143},
    '{16'd640, 16'd1048, 6'd8,  24'd1048576,  16'd1000, 1'b1, 16'd1000, 19'd1000, 24'd1048},
    '{16'd640, 16'd1049, 6'd8,  24'd1048576,  16'd1000, 1'b1, 16'd1000, 19'd1000, 24'd1048}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk("R8 evaluation ends", 64'(busy), 64'd0);
  endtask

  task automatic wr_vw(input logic [15:0] v);
    vwidth = v; vwidth_we = 1'b1;
    tick(1);
    vwidth_we = 1'b0;
  endtask

  task automatic wr_off(input bit is_y, input logic [15:0] v);
    off = v;
    if (is_y) yoff_we = 1'b1; else xoff_we = 1'b1;
    tick(1);
    xoff_we = 1'b0; yoff_we = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    // R11 reset state
    chk("R11 busy", 64'(busy), 0);
    chk("R11 vwidth", 64'(vwidth_o), 0);
    chk("R11 vheight", 64'(vheight_o), 0);
    chk("R11 line_off", 64'(line_off_o), 0);
    chk("R11 xoff", 64'(xoff_o), 0);
    chk("R11 yoff", 64'(yoff_o), 0);
    chk("R11 start", 64'(start_addr_o), 0);
    rst_n = 1'b1;
    tick(2);

    // R1 R2 R3 R4 R5 R9: geometry table
    for (int i = 0; i < NV; i++) begin
      xres = VECS[i].xres; yres = VECS[i].yres;
      bpp  = VECS[i].bpp;  vram = VECS[i].vram;
      wr_vw(VECS[i].vw);
      chk($sformatf("R1 R9 R8 busy start vec%0d", i), 64'(busy), 64'(VECS[i].starts));
      if (!VECS[i].starts)
        chk($sformatf("R1 R9 no change vec%0d", i), 64'(vwidth_o), 64'(VECS[i].e_vw));
      wait_idle();
      tick(1);
      chk($sformatf("R5 R4 vwidth vec%0d", i), 64'(vwidth_o), 64'(VECS[i].e_vw));
      chk($sformatf("R2 R4 line_off vec%0d", i), 64'(line_off_o), 64'(VECS[i].e_lo));
      chk($sformatf("R3 R4 vheight vec%0d", i), 64'(vheight_o), 64'(VECS[i].e_h));
    end

    // R6: line_off 1000, 8 bpp
    bpp = 6'd8;
    wr_off(1'b0, 16'd12);
    wr_off(1'b1, 16'd3);
    tick(3);
    chk("R6 xoff", 64'(xoff_o), 12);
    chk("R6 yoff", 64'(yoff_o), 3);
    chk("R6 start 8bpp", 64'(start_addr_o), 753);

    // R7: packed depth halves the X term
    bpp = 6'd4;
    wr_off(1'b0, 16'd13);
    tick(3);
    chk("R7 start 4bpp", 64'(start_addr_o), 751);

    // R6: 24 bpp, three bytes per pixel
    bpp = 6'd24;
    wr_off(1'b0, 16'd5);
    tick(3);
    chk("R6 start 24bpp", 64'(start_addr_o), 753);

    // R8 R10: offsets and a second width during a division
    bpp = 6'd16; xres = 16'd640; yres = 16'd480; vram = 24'd1048576;
    wr_vw(16'd800);
    chk("R8 busy high", 64'(busy), 1);
    wr_off(1'b1, 16'd10);
    wr_off(1'b0, 16'd4);
    wr_vw(16'd1024);
    chk("R8 still busy", 64'(busy), 1);
    chk("R8 xoff held", 64'(xoff_o), 5);
    chk("R8 yoff held", 64'(yoff_o), 3);
    chk("R8 start held", 64'(start_addr_o), 753);
    chk("R5 line_off held", 64'(line_off_o), 1000);
    wait_idle();
    tick(3);
    chk("R10 vwidth", 64'(vwidth_o), 800);
    chk("R10 line_off", 64'(line_off_o), 1600);
    chk("R3 vheight", 64'(vheight_o), 655);
    chk("R8 xoff applied", 64'(xoff_o), 4);
    chk("R8 yoff applied", 64'(yoff_o), 10);
    chk("R8 start new stride", 64'(start_addr_o), 4002);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule